// File: doc/BRIEF.md
# Double-Buffered Serial Control Register Bank

This block is the programming port for a frequency-synthesizer control bank. A host drives three wires: a serial clock, a data line and a latch-enable strobe. It shifts a 16-bit word in, most significant bit first, and raises latch enable to commit it. The block brings all three wires into the system clock domain through two-flop synchronizers. It then detects the rising edges of the serial clock and of latch enable. The low three bits of the word are a control field, and that field chooses which register receives the rest of the word.

A word addressed to the phase register does not reach the active phase output. It only fills a holding register. The held phase becomes active when the next word addressed to the integer/fractional register is latched. That latch loads the integer value, the fractional value and the held phase into the active outputs on the same system clock edge, and it pulses a one-cycle load strobe. Software that wants a new output phase therefore writes the phase register first and then rewrites the integer/fractional register. The phase value is meant to stay below the fractional modulus, and the host is responsible for that range.

Top module: `serial_bank_if`

## Requirements
- R1: Data is sampled on each rising edge of the serial clock into a 16-bit shift register, MSB first. At a latch-enable rise, the last 16 bits shifted in form the word, and any earlier bits are discarded.
- R2: Bits 2..0 of a word are the control field. Code 000 addresses the integer/fractional register: INT is bits 15..9 and FRAC is bits 8..3. Code 010 addresses the phase register: the phase is bits 14..3, with bit 14 as MSB.
- R3: A phase-register word updates only the holding register. The active phase keeps its value through any number of phase-register words until the next integer/fractional latch, which makes the active phase equal to the held value.
- R4: Words with control codes 001, 011, 100, 101, 110 or 111 leave INT, FRAC, phase and the load strobe unchanged.
- R5: An integer/fractional latch loads INT, FRAC and the held phase into the outputs on the same system clock edge.
- R6: The load strobe is high for exactly one system clock per integer/fractional latch. It stays low for all other words.
- R7: Bit 15 of a phase-register word has no effect on the held or active phase.
- R8: During and after reset, INT, FRAC, phase, the holding register and the load strobe are zero.
- R9: Latch enable is edge detected, so holding it high for many cycles commits the word once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| serLe | input | 1 | Latch enable; a rising edge commits the word |
| intVal | output | 7 | Active integer value |
| fracVal | output | 6 | Active fractional value |
| phaseVal | output | 12 | Active phase value |
| r0Load | output | 1 | One-cycle pulse on each integer/fractional commit |

## Verification
The embedded properties are checked on every cycle:
- the two decode strobes are mutually exclusive;
- the shift register moves only on a serial-clock edge;
- the active INT, FRAC and phase outputs stay stable whenever no integer/fractional commit occurs;
- a commit copies the held phase across.

Some behaviours are shown only by the bench's scenarios:
- repeated phase writes with no commit;
- bit 15 being ignored;
- that the last 16 bits win when a longer stream is shifted in;
- that a long latch-enable pulse yields a single load strobe;
- the field positions seen at the ports.

// File: rtl/serial_bank_pkg.sv
package serial_bank_pkg;
  localparam int CTRL_W = 3;
  localparam logic [CTRL_W-1:0] CODE_INTFRAC = 3'b000;
  localparam logic [CTRL_W-1:0] CODE_PHASE   = 3'b010;

  typedef struct packed {
    logic ldIntFrac;
    logic ldPhase;
  } strobeT;
endpackage

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
  import serial_bank_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLe,
  output strobeT            stb,
  output logic [WORD_W-1:0] word
);
  localparam int S = SYNC_STAGES;

  // Bits [S-1:0] synchronize; bit S holds the previous synced value for edge detection.
  logic [S:0]   clkSync;
  logic [S:0]   leSync;
  logic [S-1:0] dataSync;
  logic [WORD_W-1:0] shiftReg;
  logic clkRise, leRise;
  logic [CTRL_W-1:0] ctrlField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      leSync   <= '0;
      dataSync <= '0;
    end else begin
      clkSync  <= {clkSync[S-1:0], serClk};
      leSync   <= {leSync[S-1:0], serLe};
      dataSync <= {dataSync[S-2:0], serData};
    end
  end

  assign clkRise = clkSync[S-1] & ~clkSync[S];
  assign leRise  = leSync[S-1]  & ~leSync[S];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        shiftReg <= '0;
    else if (clkRise) shiftReg <= {shiftReg[WORD_W-2:0], dataSync[S-1]};
  end

  assign ctrlField     = shiftReg[CTRL_W-1:0];
  assign word          = shiftReg;
  assign stb.ldIntFrac = leRise && (ctrlField == CODE_INTFRAC);
  assign stb.ldPhase   = leRise && (ctrlField == CODE_PHASE);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldIntFrac, stb.ldPhase})); // R2
  AST_SHIFT_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !clkRise |=> $stable(shiftReg)); // R1
  AST_LE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    leRise |=> !leRise); // R9
endmodule

// File: rtl/serial_bank_dp.sv
module serial_bank_dp
  import serial_bank_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int INT_W   = 7,
  parameter int FRAC_W  = 6,
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [WORD_W-1:0]  word,
  output logic [INT_W-1:0]   intVal,
  output logic [FRAC_W-1:0]  fracVal,
  output logic [PHASE_W-1:0] phaseVal,
  output logic               r0Load
);
  localparam int FRAC_LSB  = CTRL_W;
  localparam int INT_LSB   = CTRL_W + FRAC_W;
  localparam int PHASE_LSB = CTRL_W;

  logic [PHASE_W-1:0] holdPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdPhase <= '0;
    else if (stb.ldPhase) holdPhase <= word[PHASE_LSB +: PHASE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intVal   <= '0;
      fracVal  <= '0;
      phaseVal <= '0;
      r0Load   <= 1'b0;
    end else begin
      r0Load <= stb.ldIntFrac;
      if (stb.ldIntFrac) begin
        intVal   <= word[INT_LSB +: INT_W];
        fracVal  <= word[FRAC_LSB +: FRAC_W];
        phaseVal <= holdPhase;
      end
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldIntFrac |=> $stable(phaseVal)); // R3
  AST_PHASE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldIntFrac |=> phaseVal == $past(holdPhase)); // R5
  AST_INTFRAC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldIntFrac |=> $stable(intVal) && $stable(fracVal)); // R4
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    r0Load |=> !r0Load); // R6
endmodule

// File: rtl/serial_bank_if.sv
module serial_bank_if
  import serial_bank_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int INT_W       = 7,
  parameter int FRAC_W      = 6,
  parameter int PHASE_W     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serLe,
  output logic [INT_W-1:0]   intVal,
  output logic [FRAC_W-1:0]  fracVal,
  output logic [PHASE_W-1:0] phaseVal,
  output logic               r0Load
);
  strobeT            stb;
  logic [WORD_W-1:0] word;

  serial_bank_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLe(serLe), .stb(stb), .word(word)
  );

  serial_bank_dp #(.WORD_W(WORD_W), .INT_W(INT_W), .FRAC_W(FRAC_W),
                   .PHASE_W(PHASE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .word(word),
    .intVal(intVal), .fracVal(fracVal), .phaseVal(phaseVal), .r0Load(r0Load)
  );
endmodule

// File: tb/serial_bank_if_tb.sv
`timescale 1ns/1ps
module serial_bank_if_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLe = 1'b0;
  logic [6:0]  intVal;
  logic [5:0]  fracVal;
  logic [11:0] phaseVal;
  logic        r0Load;

  int tests = 0, fails = 0;
  int pulseCnt = 0, runLen = 0, maxRun = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_bank_if u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .intVal(intVal), .fracVal(fracVal), .phaseVal(phaseVal), .r0Load(r0Load)
  );

  always @(posedge clk) begin
    if (r0Load) begin
      pulseCnt++;
      runLen++;
      if (runLen > maxRun) maxRun = runLen;
    end else runLen = 0;
  end

  function automatic logic [15:0] mkIF(logic [6:0] i, logic [5:0] f);
    return {i, f, 3'b000};
  endfunction
  function automatic logic [15:0] mkPh(logic rsv, logic [11:0] p);
    return {rsv, p, 3'b010};
  endfunction
  function automatic string reqName(int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  typedef struct packed {
    logic [15:0] word;
    logic [6:0]  eInt;
    logic [5:0]  eFrac;
    logic [11:0] ePh;
    logic [1:0]  ePulse;
    logic [3:0]  req;
  } vecT;

  localparam vecT VECS [10] = '{
    '{mkPh(1'b0, 12'hABC),   7'h00, 6'h00, 12'h000, 2'd0, 4'd3},
    '{mkPh(1'b0, 12'h123),   7'h00, 6'h00, 12'h000, 2'd0, 4'd3},
    '{mkIF(7'h55, 6'h2A),    7'h55, 6'h2A, 12'h123, 2'd1, 4'd5},
    '{16'hFFF9,              7'h55, 6'h2A, 12'h123, 2'd0, 4'd4},
    '{mkPh(1'b1, 12'hFFF),   7'h55, 6'h2A, 12'h123, 2'd0, 4'd7},
    '{mkIF(7'h7F, 6'h3F),    7'h7F, 6'h3F, 12'hFFF, 2'd1, 4'd2},
    '{16'h0007,              7'h7F, 6'h3F, 12'hFFF, 2'd0, 4'd4},
    '{mkIF(7'h00, 6'h01),    7'h00, 6'h01, 12'hFFF, 2'd1, 4'd6},
    '{mkPh(1'b0, 12'h800),   7'h00, 6'h01, 12'hFFF, 2'd0, 4'd3},
    '{mkIF(7'h01, 6'h00),    7'h01, 6'h00, 12'h800, 2'd1, 4'd5}
  };

  task automatic sendBits(logic [31:0] bits, int n, int leHold);
    pulseCnt = 0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); serData = bits[i];
      repeat (3) @(negedge clk); serClk = 1'b1;
      repeat (3) @(negedge clk); serClk = 1'b0;
    end
    repeat (3) @(negedge clk); serLe = 1'b1;
    repeat (leHold) @(negedge clk); serLe = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check(string req, logic [6:0] eI, logic [5:0] eF,
                       logic [11:0] eP, int ePulse);
    tests++;
    if (intVal !== eI || fracVal !== eF || phaseVal !== eP || pulseCnt != ePulse) begin
      fails++;
      $display("FAIL %s: got int=%h frac=%h phase=%h pulses=%0d, expected int=%h frac=%h phase=%h pulses=%0d",
               req, intVal, fracVal, phaseVal, pulseCnt, eI, eF, eP, ePulse);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R8: outputs zero while reset is held
    check("R8", 7'h00, 6'h00, 12'h000, 0);
    tests++;
    if (r0Load !== 1'b0) begin
      fails++;
      $display("FAIL R8: r0Load=%b expected 0", r0Load);
    end
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    foreach (VECS[k]) begin
      sendBits({16'h0, VECS[k].word}, 16, 4);
      check(reqName(int'(VECS[k].req)), VECS[k].eInt, VECS[k].eFrac,
            VECS[k].ePh, int'(VECS[k].ePulse));
    end

    // R1: 20 bits shifted, only the last 16 count
    sendBits({12'h0, 4'b1011, mkIF(7'h12, 6'h05)}, 20, 4);
    check("R1", 7'h12, 6'h05, 12'h800, 1);

    // R9: latch enable held high for many cycles commits once
    sendBits({16'h0, mkIF(7'h33, 6'h11)}, 16, 40);
    check("R9", 7'h33, 6'h11, 12'h800, 1);

    // R3: repeated phase writes leave active phase alone, then commit takes last
    sendBits({16'h0, mkPh(1'b0, 12'h00F)}, 16, 4);
    sendBits({16'h0, mkPh(1'b0, 12'h0F0)}, 16, 4);
    sendBits({16'h0, mkPh(1'b0, 12'h5A5)}, 16, 4);
    check("R3", 7'h33, 6'h11, 12'h800, 0);
    sendBits({16'h0, mkIF(7'h40, 6'h20)}, 16, 4);
    check("R3", 7'h40, 6'h20, 12'h5A5, 1);

    // R6: no load strobe was ever wider than one cycle
    tests++;
    if (maxRun != 1) begin
      fails++;
      $display("FAIL R6: widest r0Load run=%0d expected 1", maxRun);
    end

    // R8: reset in the middle of operation clears the holding register too
    sendBits({16'h0, mkPh(1'b0, 12'h777)}, 16, 4);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    pulseCnt = 0;
    check("R8", 7'h00, 6'h00, 12'h000, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    sendBits({16'h0, mkIF(7'h02, 6'h03)}, 16, 4);
    check("R8", 7'h02, 6'h03, 12'h000, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule